// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block moves 32-bit words from a write clock domain to an independent read clock domain. Words are held in a 512-entry memory, and the read side has one more stage: a first-word-fall-through output register. Each side has a single qualified transfer strobe. A transfer happens on a rising edge of that side's clock only when the side's chip select is low and its enable is high. On the write side, `wr_ready` is the back-pressure signal. On the read side, `rd_valid` says the output register holds data. The write pointer and the read pointer each cross to the other domain as Gray code through a two-flop synchronizer. Each domain therefore sees a stale view of the other side, and that view can only make the flags more cautious.

Each side also has an active-low threshold flag, registered in its own domain. The write side has almost-full and the read side has almost-empty. Their offsets are chosen by a two-bit select that is sampled on the first write-clock edge after reset is released. Three of the select values pick a built-in preset. The fourth value turns the first four accepted writes into programming words, which load the offsets and are never stored as data.

Stream rules: a write is accepted only on an edge where `wr_ready` was already high. A producer may hold its word and strobe for as long as it likes. A strobe given while `wr_ready` is low has no effect. A read pops the output register only on an edge where `rd_valid` is high. While no pop happens, `rd_data` and `rd_valid` hold. A read strobe given while `rd_valid` is low is ignored.

Top module: `flagged_async_fifo`

## Requirements
- R1: A write or read takes effect only on a rising edge of its own clock with its chip select low and its enable high. A strobe with chip select high or enable low stores nothing and pops nothing.
- R2: `wr_ready` is low while `rst_n` is low and on the first write-clock edge after release. It goes high on the second write-clock edge after release.
- R3: The store holds 512 words in memory plus one in the output register. When the memory is full, `wr_ready` is low, and a write strobe given then stores nothing.
- R4: `rd_valid` is low while the FIFO is empty. After a word is written into an empty FIFO, `rd_valid` rises on the third read-clock edge after that write edge, and `rd_data` already shows the word.
- R5: Words leave in the order they were accepted. A read with `rd_valid` high moves the next stored word into `rd_data`, or drops `rd_valid` if nothing is left. Without a read, `rd_data` holds.
- R6: `offset_sel` is sampled on the first write-clock edge after reset release. The value 01 selects 8, 10 selects 16 and 11 selects 64, and the chosen value is used for both thresholds.
- R7: When `offset_sel` is 00, the first four accepted writes are programming words and none of them is stored. Bits [8:0] of word 0 set the almost-empty offset. Bits [8:0] of word 1 set the almost-full offset. Words 2 and 3 are consumed and discarded.
- R8: `rd_almost_empty_n` is registered on the read clock. It is low while the stored count (memory words seen by the read side plus the output register) is at or below the almost-empty offset, and it is low during reset.
- R9: `wr_almost_full_n` is registered on the write clock. It is low while the free memory locations (512 minus words written and not yet moved to the output register) number at or below the almost-full offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset for both domains |
| offset_sel | input | 2 | Threshold source select, sampled after reset release |
| wr_cs_n | input | 1 | Write chip select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 32 | Write word |
| wr_ready | output | 1 | Write side can accept a word |
| wr_almost_full_n | output | 1 | Almost-full flag, active low |
| rd_cs_n | input | 1 | Read chip select, active low |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | 32 | Output register contents |
| rd_valid | output | 1 | Output register holds a word |
| rd_almost_empty_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench counts read-clock edges after a single write into an empty FIFO. A design with one synchronizer stage too few or too many raises `rd_valid` an edge early or late. It fills the FIFO to its 513-word capacity and then strobes once more. A design that ignores `wr_ready` overwrites an unread word, and the drain shows either a corrupted sequence or one extra word. It places both flags exactly on either side of every threshold: each preset, programmed offsets, and the count that includes the output register. An off-by-one comparison, or a count that leaves out the output stage, flips a flag one word away from where it should. It also checks that programming words never come out as data and that strobes with only one qualifier active change nothing.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;
  typedef enum logic [1:0] {
    OFS_PROGRAM = 2'b00,
    OFS_SMALL   = 2'b01,
    OFS_MEDIUM  = 2'b10,
    OFS_LARGE   = 2'b11
  } ofs_sel_e;

  function automatic int unsigned preset_offset(input ofs_sel_e sel);
    case (sel)
      OFS_SMALL:  return 8;
      OFS_MEDIUM: return 16;
      OFS_LARGE:  return 64;
      default:    return 0;
    endcase
  endfunction
endpackage

// File: rtl/afifo_sync.sv
`timescale 1ns/1ps
module afifo_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/afifo_wr_ctrl.sv
`timescale 1ns/1ps
module afifo_wr_ctrl
  import afifo_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sel,
  input  logic          cs_n,
  input  logic          en,
  input  logic [DW-1:0] data,
  input  logic [AW:0]   rgray_s,
  output logic          ready,
  output logic          af_n,
  output logic          push,
  output logic          started,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [1:0]    boot;
  logic          prog_mode;
  logic [2:0]    prog_cnt;
  logic [PW-1:0] wbin, wbin_n, rbin_s, used_n, free_n;
  logic          xfer, prog_phase, full_n;

  assign started    = (boot == 2'd2);
  assign xfer       = !cs_n && en && ready;
  assign prog_phase = prog_mode && (prog_cnt < 3'd4);
  assign push       = xfer && !prog_phase;
  assign waddr      = wbin[AW-1:0];

  always_comb begin
    rbin_s = g2b(rgray_s);
    wbin_n = wbin + PW'(push);
    used_n = wbin_n - rbin_s;
    full_n = used_n[AW];
    free_n = DEPTH - used_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot      <= '0;
      prog_mode <= 1'b0;
      prog_cnt  <= '0;
      ae_off    <= '0;
      af_off    <= '0;
      wbin      <= '0;
      wgray     <= '0;
      ready     <= 1'b0;
      af_n      <= 1'b1;
    end else begin
      if (!started) boot <= boot + 2'd1;
      if (boot == 2'd0) begin
        prog_mode <= (ofs_sel_e'(sel) == OFS_PROGRAM);
        ae_off    <= AW'(preset_offset(ofs_sel_e'(sel)));
        af_off    <= AW'(preset_offset(ofs_sel_e'(sel)));
      end
      if (xfer && prog_phase) begin
        prog_cnt <= prog_cnt + 3'd1;
        case (prog_cnt)
          3'd0:    ae_off <= data[AW-1:0];
          3'd1:    af_off <= data[AW-1:0];
          default: ;
        endcase
      end
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
      ready <= (boot != 2'd0) && !full_n;
      af_n  <= !(free_n <= {1'b0, af_off});
    end
  end
endmodule

// File: rtl/afifo_rd_ctrl.sv
`timescale 1ns/1ps
module afifo_rd_ctrl #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          en,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_off,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          ae_n
);
  localparam int PW = AW + 1;
  localparam int CW = AW + 2;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin, rbin_n, wbin_s;
  logic [CW-1:0] cnt_n;
  logic          pop, load, mem_empty, rvalid_n;

  assign raddr = rbin[AW-1:0];

  always_comb begin
    wbin_s    = g2b(wgray_s);
    mem_empty = (rbin == wbin_s);
    pop       = rvalid && !cs_n && en;
    load      = (!rvalid || pop) && !mem_empty;
    rbin_n    = rbin + PW'(load);
    rvalid_n  = load || (rvalid && !pop);
    cnt_n     = CW'(wbin_s - rbin_n) + CW'(rvalid_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
      ae_n   <= 1'b0;
    end else begin
      if (load) rdata <= mem_q;
      rbin   <= rbin_n;
      rgray  <= rbin_n ^ (rbin_n >> 1);
      rvalid <= rvalid_n;
      ae_n   <= !(cnt_n <= CW'(ae_off));
    end
  end
endmodule

// File: rtl/flagged_async_fifo.sv
`timescale 1ns/1ps
module flagged_async_fifo #(
  parameter int DW = 32,
  parameter int AW = 9
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [1:0]    offset_sel,
  input  logic          wr_cs_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          wr_almost_full_n,
  input  logic          rd_cs_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_almost_empty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q;
  logic [AW-1:0] waddr, raddr, ae_off, af_off;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic          push, wr_started;

  afifo_wr_ctrl #(.AW(AW), .DW(DW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .sel(offset_sel), .cs_n(wr_cs_n), .en(wr_en),
    .data(wr_data), .rgray_s(rgray_s), .ready(wr_ready), .af_n(wr_almost_full_n),
    .push(push), .started(wr_started), .waddr(waddr), .wgray(wgray),
    .ae_off(ae_off), .af_off(af_off)
  );

  afifo_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));
  afifo_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

  always_ff @(posedge wr_clk) begin
    if (push) mem[waddr] <= wr_data;
  end
  assign mem_q = mem[raddr];

  afifo_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .cs_n(rd_cs_n), .en(rd_en), .wgray_s(wgray_s),
    .ae_off(ae_off), .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
    .rdata(rd_data), .rvalid(rd_valid), .ae_n(rd_almost_empty_n)
  );
endmodule

// File: rtl/flagged_async_fifo_chk.sv
`timescale 1ns/1ps
module flagged_async_fifo_chk #(
  parameter int DW = 32,
  parameter int AW = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_ready,
  input logic          wr_almost_full_n,
  input logic          wr_started,
  input logic [AW:0]   wgray,
  input logic          rd_cs_n,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          rd_almost_empty_n
);
  // R2
  boot_gate_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_started |-> !wr_ready);

  // R1
  blocked_write_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_ready |=> $stable(wgray));

  // R9
  full_flag_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_started && !wr_ready) |-> !wr_almost_full_n);

  // R8
  empty_flag_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_valid |-> !rd_almost_empty_n);

  // R5
  hold_output_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_valid && !(!rd_cs_n && rd_en)) |=> (rd_valid && $stable(rd_data)));
endmodule

bind flagged_async_fifo flagged_async_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_ready(wr_ready),
  .wr_almost_full_n(wr_almost_full_n), .wr_started(wr_started), .wgray(wgray),
  .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
  .rd_almost_empty_n(rd_almost_empty_n)
);

// File: tb/flagged_async_fifo_bench.sv
`timescale 1ns/1ps
module flagged_async_fifo_bench;
  logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  offset_sel = 2'b01;
  logic        wr_cs_n = 1'b1, wr_en = 1'b0, rd_cs_n = 1'b1, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, wr_almost_full_n, rd_valid, rd_almost_empty_n;
  logic [31:0] rd_data;

  int checks = 0, failures = 0, wseq = 0;
  bit done = 0;
  logic [31:0] model[$];

  flagged_async_fifo u_flagged_async_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .offset_sel(offset_sel),
    .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
    .wr_almost_full_n(wr_almost_full_n), .rd_cs_n(rd_cs_n), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_almost_empty_n(rd_almost_empty_n)
  );

  always #2.5 wr_clk = ~wr_clk;
  initial begin
    #1;
    forever begin rd_clk = ~rd_clk; #2.5; end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge rd_clk);
  endtask

  task automatic do_reset(input logic [1:0] sel, input bit chk_boot);
    rst_n = 1'b0;
    offset_sel = sel;
    model.delete();
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    @(negedge wr_clk);
    if (chk_boot) check("R2", "wr_ready after first edge", 32'(wr_ready), 32'd0);
    @(negedge wr_clk);
    if (chk_boot) check("R2", "wr_ready after second edge", 32'(wr_ready), 32'd1);
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic wr_one(input logic [31:0] d, input bit store);
    @(negedge wr_clk);
    while (!wr_ready) @(negedge wr_clk);
    wr_data = d; wr_cs_n = 1'b0; wr_en = 1'b1;
    if (store) model.push_back(d);
    @(negedge wr_clk);
    wr_cs_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic wr_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      while (!wr_ready) begin
        wr_cs_n = 1'b1; wr_en = 1'b0;
        @(negedge wr_clk);
      end
      wseq++;
      wr_data = {wseq[15:0] ^ 16'h5A5A, wseq[15:0]};
      wr_cs_n = 1'b0; wr_en = 1'b1;
      model.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_cs_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic rd_words(input int n, input string req);
    int bad = 0;
    logic [31:0] exp;
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      while (!rd_valid) begin
        rd_en = 1'b0;
        @(negedge rd_clk);
      end
      exp = (model.size() > 0) ? model.pop_front() : 32'hFFFF_FFFF;
      if (rd_data !== exp) bad++;
      rd_cs_n = 1'b0; rd_en = 1'b1;
    end
    @(negedge rd_clk);
    rd_cs_n = 1'b1; rd_en = 1'b0;
    check(req, "words out of order", 32'(bad), 32'd0);
  endtask

  // R2 R4 R8 R9: state right after reset
  task automatic t_boot();
    do_reset(2'b01, 1);
    check("R4", "rd_valid empty", 32'(rd_valid), 32'd0);
    check("R8", "almost-empty after reset", 32'(rd_almost_empty_n), 32'd0);
    check("R9", "almost-full after reset", 32'(wr_almost_full_n), 32'd1);
  endtask

  // R4: three read edges from write into empty FIFO to rd_valid
  task automatic t_latency();
    @(negedge wr_clk);
    wseq++;
    wr_data = 32'hC0DE_0000 | 32'(wseq);
    wr_cs_n = 1'b0; wr_en = 1'b1;
    model.push_back(wr_data);
    @(posedge wr_clk);
    #0.5;
    wr_cs_n = 1'b1; wr_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge rd_clk);
      check("R4", $sformatf("rd_valid after %0d read edges", i), 32'(rd_valid), 32'(i == 3));
    end
    check("R4", "data present with rd_valid", rd_data, model[0]);
    rd_words(1, "R5");
  endtask

  // R6 R8 R9 R3 R5: preset 8, fill, overflow, drain
  task automatic t_preset_small();
    wr_words(8); settle();
    check("R6", "ae at count 8 (offset 8)", 32'(rd_almost_empty_n), 32'd0);
    wr_words(1); settle();
    check("R8", "ae at count 9 (offset 8)", 32'(rd_almost_empty_n), 32'd1);
    wr_words(495); settle();
    check("R9", "af with 9 free", 32'(wr_almost_full_n), 32'd1);
    wr_words(1); settle();
    check("R9", "af with 8 free", 32'(wr_almost_full_n), 32'd0);
    wr_words(8); settle();
    check("R3", "wr_ready at 513 stored", 32'(wr_ready), 32'd0);
    @(negedge wr_clk);
    wr_data = 32'hDEAD_BEEF; wr_cs_n = 1'b0; wr_en = 1'b1;
    repeat (4) @(negedge wr_clk);
    wr_cs_n = 1'b1; wr_en = 1'b0;
    check("R3", "model depth", 32'(model.size()), 32'd513);
    rd_words(513, "R5");
    settle();
    check("R3", "no word after drain", 32'(rd_valid), 32'd0);
    check("R8", "ae after drain", 32'(rd_almost_empty_n), 32'd0);
  endtask

  // R1 R5 R6: qualifiers, hold, preset 16
  task automatic t_qualify();
    do_reset(2'b10, 0);
    @(negedge wr_clk);
    wr_data = 32'h1111_1111; wr_cs_n = 1'b1; wr_en = 1'b1;
    repeat (2) @(negedge wr_clk);
    wr_cs_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge wr_clk);
    wr_cs_n = 1'b1;
    settle();
    check("R1", "unqualified writes store nothing", 32'(rd_valid), 32'd0);
    wr_words(2); settle();
    check("R1", "qualified write shows", rd_data, model[0]);
    @(negedge rd_clk);
    rd_cs_n = 1'b1; rd_en = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_cs_n = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge rd_clk);
    rd_cs_n = 1'b1;
    check("R1", "unqualified reads pop nothing", rd_data, model[0]);
    check("R5", "rd_valid held", 32'(rd_valid), 32'd1);
    rd_words(1, "R5");
    settle();
    check("R5", "next word presented", rd_data, model[0]);
    wr_words(15); settle();
    check("R6", "ae at count 16 (offset 16)", 32'(rd_almost_empty_n), 32'd0);
    wr_words(1); settle();
    check("R6", "ae at count 17 (offset 16)", 32'(rd_almost_empty_n), 32'd1);
  endtask

  // R6: preset 64
  task automatic t_preset_large();
    do_reset(2'b11, 0);
    wr_words(64); settle();
    check("R6", "ae at count 64 (offset 64)", 32'(rd_almost_empty_n), 32'd0);
    wr_words(1); settle();
    check("R6", "ae at count 65 (offset 64)", 32'(rd_almost_empty_n), 32'd1);
  endtask

  // R7: programming words
  task automatic t_program();
    do_reset(2'b00, 0);
    wr_one(32'hFFFF_FE03, 0);
    wr_one(32'hABCD_0005, 0);
    wr_one(32'h0BAD_0001, 0);
    wr_one(32'h0BAD_0002, 0);
    settle();
    check("R7", "programming words not stored", 32'(rd_valid), 32'd0);
    wr_words(3); settle();
    check("R7", "ae at count 3 (offset 3)", 32'(rd_almost_empty_n), 32'd0);
    check("R7", "first data word out", rd_data, model[0]);
    wr_words(1); settle();
    check("R7", "ae at count 4 (offset 3)", 32'(rd_almost_empty_n), 32'd1);
    wr_words(503); settle();
    check("R7", "af with 6 free (offset 5)", 32'(wr_almost_full_n), 32'd1);
    wr_words(1); settle();
    check("R9", "af with 5 free (offset 5)", 32'(wr_almost_full_n), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_boot();
    t_latency();
    t_preset_small();
    t_qualify();
    t_preset_large();
    t_program();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule